// File: doc/BRIEF.md
# Continuous-Mode Compare Timer

This block is a free-running up-counter, 24 bits wide by default, paired with a programmable compare register and a sticky match flag. The counter advances once per clock when the run bit is set and the prescaled `tick` input is high. When the counter steps onto the compare value, the match flag is raised. The counter does not reload or stop on a match. It runs through its full range, wraps to zero and carries on, so one pass can hit several rising compare targets.

Software drives the block through a small write-only register port. It can start or freeze the counter, enable the interrupt, load a new compare target and clear the flag by writing a one to it. It is meant for event scheduling. After each match, software clears the flag and writes the next, larger target while the counter keeps running. A separate synchronous input returns the counter to zero without touching the other settings.

Top module: `cmp_timer`

## Requirements
- R1: `count_o` increases by exactly one on every rising clock edge where the run bit (control register, address 0, bit 0) is 1 and `tick` is high. It holds its value on edges where `tick` is low.
- R2: A write to address 1 loads `cmp_o` only when the written value is greater than 1. A write of 0 or 1 leaves `cmp_o` unchanged. The value 2 is accepted.
- R3: The status flag `status_o` goes to 1 on the same edge at which `count_o` becomes equal to `cmp_o`. The first cycle in which `status_o` reads 1 therefore shows `count_o == cmp_o`.
- R4: After 2^CNT_W-1 the counter goes to 0 on the next counting edge and keeps counting up. A compare target is hit again on each later pass.
- R5: The status flag stays at 1 until a write to address 2 with bit 0 set clears it. If a match happens on the same edge as that clearing write, the flag ends up at 1.
- R6: `irq_o` is 1 exactly when the status flag is 1 and the interrupt-enable bit (address 0, bit 1) is 1.
- R7: A match changes neither the run bit nor the counting. The counter keeps advancing by one per counting edge while the flag is 1.
- R8: With the run bit at 0, `count_o` keeps its value even when `tick` is high.
- R9: `cnt_clr` high at a clock edge sets `count_o` to 0, taking priority over counting. It does not change `cmp_o`.
- R10: After `rst_n` is released, `count_o` is 0, the status flag and `irq_o` are 0, both control bits are 0, and `cmp_o` is 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| cnt_clr | input | 1 | Synchronous counter clear |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 compare, 2 status clear |
| reg_wdata | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| cmp_o | output | CNT_W | Current compare target |
| status_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request (flag masked by enable) |

## Verification
Every result of this block is due one rising edge after its cause:
- A register write is visible at the edge where the strobe is sampled.
- A counting edge moves `count_o` and, on a match, raises `status_o` at that same edge.
- `irq_o` follows the flag and the enable bit without delay.

The bench changes inputs on the falling edge and samples on the next falling edge, so each sample sees the state exactly one edge after the stimulus. Multi-edge expectations, such as the count four edges after a match, are counted from that same reference point. Match detection waits in a bounded loop for the first cycle with the flag set and then checks that the count equals the target in that very cycle.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IE_BIT  = 1;

  // Next counter value for a counter of width w, wrapping to zero.
  function automatic logic [31:0] cnt_advance(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v + 32'd1) & mask;
  endfunction

  // A compare target is usable only when it is above one.
  function automatic logic cmp_ok(input logic [31:0] v);
    return v > 32'd1;
  endfunction

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic             run,
  output logic             irq_en,
  output logic [CNT_W-1:0] cmp,
  output logic             stat_clr,
  output logic             ctrl_we
);

  logic cmp_we;
  logic cmp_accept;

  assign ctrl_we    = reg_wr && (reg_addr == ADDR_CTRL);
  assign cmp_we     = reg_wr && (reg_addr == ADDR_CMP);
  assign cmp_accept = cmp_we && cmp_ok(32'(reg_wdata));
  assign stat_clr   = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      irq_en <= 1'b0;
    end else if (ctrl_we) begin
      run    <= reg_wdata[CTRL_RUN_BIT];
      irq_en <= reg_wdata[CTRL_IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmp <= '1;
    else if (cmp_accept) cmp <= reg_wdata;
  end

  // R2
  cmp_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && reg_wdata <= CNT_W'(1)) |=> $stable(cmp));

  // R2
  cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && reg_wdata > CNT_W'(1)) |=> (cmp == $past(reg_wdata)));

  // R2
  cmp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp > CNT_W'(1));

endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt,
  output logic             adv
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign nxt = CNT_W'(cnt_advance(32'(cnt), CNT_W));
  assign adv = step && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= nxt;
  end

  // R1
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt != CNT_MAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt == CNT_MAX) |=> (cnt == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(cnt));

  // R9
  sync_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] nxt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             stat_clr,
  output logic             hit,
  output logic             status
);

  assign hit = adv && (nxt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status <= 1'b0;
    else if (hit)      status <= 1'b1;
    else if (stat_clr) status <= 1'b0;
  end

  // R3
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !stat_clr) |=> status);

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !hit) |=> !status);

  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status && !hit) |=> !status);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_clr,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             status_o,
  output logic             irq_o
);

  logic             run;
  logic             irq_en;
  logic             stat_clr;
  logic             ctrl_we;
  logic             step;
  logic             adv;
  logic             hit;
  logic [CNT_W-1:0] nxt;

  cmp_timer_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .run(run), .irq_en(irq_en), .cmp(cmp_o),
    .stat_clr(stat_clr), .ctrl_we(ctrl_we)
  );

  assign step = run && tick;

  cmp_timer_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(cnt_clr),
    .cnt(count_o), .nxt(nxt), .adv(adv)
  );

  cmp_timer_match #(.CNT_W(CNT_W)) match_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .nxt(nxt), .cmp(cmp_o),
    .stat_clr(stat_clr), .hit(hit), .status(status_o)
  );

  assign irq_o = status_o && irq_en;

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> status_o);

  // R7
  run_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ctrl_we) |=> run);

  // R7
  keeps_counting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o && adv) |=> (count_o != $past(count_o)));

endmodule

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;

  localparam int W  = 24;
  localparam int WN = 8;
  localparam int unsigned CMPV [3] = '{80, 200, 500};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cnt_clr = 1'b0;

  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [W-1:0]  reg_wdata = '0;
  logic [W-1:0]  count_o, cmp_o;
  logic          status_o, irq_o;

  logic          w_wr = 1'b0;
  logic [1:0]    w_addr = 2'd0;
  logic [WN-1:0] w_data = '0;
  logic [WN-1:0] w_count, w_cmp;
  logic          w_status, w_irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cmp_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_clr(cnt_clr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .count_o(count_o), .cmp_o(cmp_o), .status_o(status_o), .irq_o(irq_o)
  );

  cmp_timer #(.CNT_W(WN)) dut_w (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_clr(cnt_clr),
    .reg_wr(w_wr), .reg_addr(w_addr), .reg_wdata(w_data),
    .count_o(w_count), .cmp_o(w_cmp), .status_o(w_status), .irq_o(w_irq)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wrw(input logic [1:0] a, input logic [WN-1:0] d);
    w_wr = 1'b1; w_addr = a; w_data = d;
    @(negedge clk);
    w_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog all act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic found;
    logic [W-1:0] c;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(count_o == 0, "R10 count", 32'(count_o), 0);
    chk(status_o == 0, "R10 status", 32'(status_o), 0);
    chk(irq_o == 0, "R10 irq", 32'(irq_o), 0);
    chk(cmp_o == {W{1'b1}}, "R10 cmp", 32'(cmp_o), 32'h00FF_FFFF);
    chk(w_cmp == 8'hFF, "R10 narrow cmp", 32'(w_cmp), 255);

    // control: run=1, irq enable=1, tick still low
    wr(2'd0, W'(3));

    // table walk: rising compare targets on one running counter
    for (int i = 0; i < 3; i++) begin
      wr(2'd2, W'(1));
      chk(status_o == 0, "R5 clear", 32'(status_o), 0);
      wr(2'd1, W'(CMPV[i]));
      tick = 1'b1;
      found = 1'b0;
      for (int n = 0; n < 2000 && !found; n++) begin
        @(negedge clk);
        if (status_o) found = 1'b1;
      end
      chk(found, "R3 flag rises", 32'(found), 1);
      chk(count_o == W'(CMPV[i]), "R3 count at match", 32'(count_o), CMPV[i]);
      chk(irq_o == 1, "R6 irq with enable", 32'(irq_o), 1);
      repeat (4) @(negedge clk);
      chk(status_o == 1, "R5 sticky", 32'(status_o), 1);
      chk(count_o == W'(CMPV[i] + 4), "R7 keeps counting", 32'(count_o), CMPV[i] + 4);
    end

    // R2 rejected and boundary compare writes
    wr(2'd1, W'(1));
    chk(cmp_o == W'(500), "R2 reject 1", 32'(cmp_o), 500);
    wr(2'd1, W'(0));
    chk(cmp_o == W'(500), "R2 reject 0", 32'(cmp_o), 500);
    wr(2'd1, W'(2));
    chk(cmp_o == W'(2), "R2 accept 2", 32'(cmp_o), 2);

    // R6 mask
    wr(2'd0, W'(1));
    chk(status_o == 1 && irq_o == 0, "R6 masked irq", 32'(irq_o), 0);

    // R8 run cleared freezes the count
    wr(2'd0, W'(0));
    c = count_o;
    repeat (5) @(negedge clk);
    chk(count_o == c, "R8 frozen", 32'(count_o), 32'(c));

    // R1 tick low holds, one tick steps once
    tick = 1'b0;
    wr(2'd0, W'(1));
    c = count_o;
    repeat (3) @(negedge clk);
    chk(count_o == c, "R1 tick low hold", 32'(count_o), 32'(c));
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(count_o == W'(c + 1), "R1 single step", 32'(count_o), 32'(c) + 1);

    // R9 sync clear wins over counting
    tick = 1'b1; cnt_clr = 1'b1;
    @(negedge clk);
    tick = 1'b0; cnt_clr = 1'b0;
    chk(count_o == 0, "R9 clear", 32'(count_o), 0);
    chk(cmp_o == W'(2), "R9 compare kept", 32'(cmp_o), 2);

    // R5 match on the same edge as the clearing write
    wr(2'd1, W'(6));
    wr(2'd2, W'(1));
    chk(status_o == 0, "R5 cleared", 32'(status_o), 0);
    tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    chk(count_o == 5 && status_o == 0, "R3 no early flag", 32'(count_o), 5);
    tick = 1'b1;
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = W'(1);
    @(negedge clk);
    tick = 1'b0; reg_wr = 1'b0;
    chk(status_o == 1, "R5 set wins", 32'(status_o), 1);
    chk(count_o == 6, "R3 count 6", 32'(count_o), 6);

    // R4 wrap on the narrow instance
    wrw(2'd1, WN'(5));
    wrw(2'd0, WN'(1));
    tick = 1'b1;
    found = 1'b0;
    for (int n = 0; n < 300 && !found; n++) begin
      @(negedge clk);
      if (w_status) found = 1'b1;
    end
    chk(found && w_count == 5, "R3 narrow first hit", 32'(w_count), 5);
    wrw(2'd2, WN'(1));
    found = 1'b0;
    for (int n = 0; n < 400 && !found; n++) begin
      @(negedge clk);
      if (w_count == 8'hFF) found = 1'b1;
    end
    chk(found, "R4 reached max", 32'(w_count), 255);
    @(negedge clk);
    chk(w_count == 0, "R4 wrap to zero", 32'(w_count), 0);
    found = 1'b0;
    for (int n = 0; n < 300 && !found; n++) begin
      @(negedge clk);
      if (w_status) found = 1'b1;
    end
    chk(found && w_count == 5, "R4 hit after wrap", 32'(w_count), 5);
    tick = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule